// File: doc/BRIEF.md
# Interrupt-Capable GPIO Controller

This block is a bank of general-purpose pins behind a simple memory-mapped register port. The port has an address, a write strobe, write data and combinational read data. Software picks the direction of each pin and changes the output levels with two strobe registers. One register forces marked pins high and the other forces marked pins low, so no read-modify-write is needed. Each pin's input level passes through a synchronizer before it can be read back or used for interrupt detection.

Every pin can raise an interrupt. Three configuration words decide the trigger: edge or level, one edge or both edges, and polarity. Detected events latch into a raw status word, gated by a per-pin enable. A mask word hides status bits from the masked status view. The single interrupt output is asserted while any masked status bit is set. Status bits are cleared by writing ones to an acknowledge register. The block exports output-enable and output-value vectors for the pad ring to use.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, pin_oe_o and pin_out_o are 0 and irq_o is low. The register offsets are: 0x04 synchronized pin level, 0x08 direction, 0x10 output set, 0x14 output clear, 0x20 interrupt enable, 0x24 raw status, 0x28 masked status, 0x2C mask, 0x30 acknowledge, 0x34 trigger method, 0x38 both-edges select, 0x3C polarity.
- R2: A 1 in direction bit n drives pin_oe_o[n] high and makes pin n an output. A 0 makes it an input. The change appears one clock after the write.
- R3: A write to 0x10 sets every output bit whose write-data bit is 1. A write to 0x14 clears every output bit whose write-data bit is 1. All other output bits keep their value. Both offsets read back the current output word.
- R4: Offset 0x04 reads the pin levels through a two-flop synchronizer. A pin change is first visible after two rising clock edges.
- R5: With method bit 0 (edge) and both-edges bit 0, polarity 0 latches a rising edge and polarity 1 latches a falling edge. The opposite edge is ignored. The raw bit sets on the third clock edge after the pin changes.
- R6: With method bit 0 and both-edges bit 1, either transition latches the raw bit, whatever the polarity bit holds.
- R7: With method bit 1 (level), polarity 0 latches while the pin is high and polarity 1 latches while the pin is low. If the level is still active after an acknowledge, the bit sets again on the next clock.
- R8: A raw status bit sets only when its enable bit is 1. Events on pins that are not enabled leave the raw status unchanged.
- R9: Writing ones to 0x30 clears exactly the marked raw bits. An acknowledge takes priority over an event on the same clock. Raw bits that are not marked keep their value.
- R10: Masked status at 0x28 equals raw AND NOT mask. irq_o is high exactly when the masked status is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data of the addressed register |
| pin_i | input | PIN_N (32) | Asynchronous pin levels |
| pin_oe_o | output | PIN_N (32) | Per-pin output enable |
| pin_out_o | output | PIN_N (32) | Per-pin output value |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong trigger decode or a missing enable gate shows up as a raw status bit that is set or clear at the wrong time. It is visible at the read port and on irq_o exactly three edges after the pin moves, and the bench samples at that cycle and one cycle earlier. A clear-versus-set priority error shows up one clock after an acknowledge, as the level-mode bit reads back as still set or never re-sets. Errors in the output or direction words show up on the pad vectors one clock after the write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam logic [7:0] OFS_PIN_LEVEL = 8'h04;
   localparam logic [7:0] OFS_DIR       = 8'h08;
   localparam logic [7:0] OFS_OUT_SET   = 8'h10;
   localparam logic [7:0] OFS_OUT_CLR   = 8'h14;
   localparam logic [7:0] OFS_IRQ_EN    = 8'h20;
   localparam logic [7:0] OFS_RAW       = 8'h24;
   localparam logic [7:0] OFS_PENDING   = 8'h28;
   localparam logic [7:0] OFS_MASK      = 8'h2C;
   localparam logic [7:0] OFS_ACK       = 8'h30;
   localparam logic [7:0] OFS_METHOD    = 8'h34;
   localparam logic [7:0] OFS_DUAL      = 8'h38;
   localparam logic [7:0] OFS_POLARITY  = 8'h3C;

   typedef struct packed {
      logic dir;
      logic set;
      logic clr;
      logic en;
      logic mask;
      logic ack;
      logic method;
      logic dual;
      logic pol;
   } wr_strobe_t;

   function automatic wr_strobe_t decode_write(input logic [7:0] ofs, input logic we);
      wr_strobe_t s;
      s        = '0;
      s.dir    = we && (ofs == OFS_DIR);
      s.set    = we && (ofs == OFS_OUT_SET);
      s.clr    = we && (ofs == OFS_OUT_CLR);
      s.en     = we && (ofs == OFS_IRQ_EN);
      s.mask   = we && (ofs == OFS_MASK);
      s.ack    = we && (ofs == OFS_ACK);
      s.method = we && (ofs == OFS_METHOD);
      s.dual   = we && (ofs == OFS_DUAL);
      s.pol    = we && (ofs == OFS_POLARITY);
      return s;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= '0;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= '0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] method,
   input  logic [W-1:0] dual,
   input  logic [W-1:0] pol,
   output logic [W-1:0] evt
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   generate
      for (genvar p = 0; p < W; p++) begin : g_pin
         logic rise, fall, edge_hit, level_hit;
         always_comb begin
            rise      = lvl[p] & ~prev_q[p];
            fall      = ~lvl[p] & prev_q[p];
            if (dual[p])     edge_hit = rise | fall;
            else if (pol[p]) edge_hit = fall;
            else             edge_hit = rise;
            level_hit = pol[p] ? ~lvl[p] : lvl[p];
            evt[p]    = method[p] ? level_hit : edge_hit;
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PIN_N  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [PIN_N-1:0]  lvl,
   input  logic [PIN_N-1:0]  evt,
   output logic [PIN_N-1:0]  dir_q,
   output logic [PIN_N-1:0]  out_q,
   output logic [PIN_N-1:0]  en_q,
   output logic [PIN_N-1:0]  mask_q,
   output logic [PIN_N-1:0]  raw_q,
   output logic [PIN_N-1:0]  method_q,
   output logic [PIN_N-1:0]  dual_q,
   output logic [PIN_N-1:0]  pol_q,
   output logic [PIN_N-1:0]  pending
);
   localparam int unsigned PAD_W = DATA_W - PIN_N;

   logic [7:0]       ofs;
   wr_strobe_t       stb;
   logic [PIN_N-1:0] wbits;
   logic [PIN_N-1:0] ack_bits;

   generate
      if (ADDR_W > 8) begin : g_wide
         logic upper_zero;
         assign upper_zero = (addr[ADDR_W-1:8] == '0);
         assign ofs = upper_zero ? addr[7:0] : 8'hFF;
      end else begin : g_narrow
         assign ofs = 8'(addr);
      end
   endgenerate

   assign stb      = decode_write(ofs, we);
   assign wbits    = wdata[PIN_N-1:0];
   assign ack_bits = stb.ack ? wbits : '0;
   assign pending  = raw_q & ~mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q    <= '0;
         out_q    <= '0;
         en_q     <= '0;
         mask_q   <= '0;
         raw_q    <= '0;
         method_q <= '0;
         dual_q   <= '0;
         pol_q    <= '0;
      end else begin
         if (stb.dir)    dir_q    <= wbits;
         if (stb.set)    out_q    <= out_q | wbits;
         if (stb.clr)    out_q    <= out_q & ~wbits;
         if (stb.en)     en_q     <= wbits;
         if (stb.mask)   mask_q   <= wbits;
         if (stb.method) method_q <= wbits;
         if (stb.dual)   dual_q   <= wbits;
         if (stb.pol)    pol_q    <= wbits;
         raw_q <= (raw_q | (evt & en_q)) & ~ack_bits;
      end
   end

   logic [PIN_N-1:0] sel;
   always_comb begin
      case (ofs)
         OFS_PIN_LEVEL: sel = lvl;
         OFS_DIR:       sel = dir_q;
         OFS_OUT_SET:   sel = out_q;
         OFS_OUT_CLR:   sel = out_q;
         OFS_IRQ_EN:    sel = en_q;
         OFS_RAW:       sel = raw_q;
         OFS_PENDING:   sel = pending;
         OFS_MASK:      sel = mask_q;
         OFS_METHOD:    sel = method_q;
         OFS_DUAL:      sel = dual_q;
         OFS_POLARITY:  sel = pol_q;
         default:       sel = '0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         if (DATA_W > PIN_N) begin : g_unused
            logic unused_hi;
            assign unused_hi = ^wdata[DATA_W-1:PIN_N];
         end
         assign rdata = {{PAD_W{1'b0}}, sel};
      end else begin : g_full
         assign rdata = sel;
      end
   endgenerate
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
   parameter int unsigned PIN_N       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PIN_N-1:0]  pin_i,
   output logic [PIN_N-1:0]  pin_oe_o,
   output logic [PIN_N-1:0]  pin_out_o,
   output logic              irq_o
);
   generate
      if (PIN_N < 1 || PIN_N > DATA_W) begin : g_bad_pins
         $error("PIN_N must lie between 1 and DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x3C");
      end
   endgenerate

   logic [PIN_N-1:0] lvl_s;
   logic [PIN_N-1:0] evt;
   logic [PIN_N-1:0] dir_q, out_q, en_q, mask_q, raw_q;
   logic [PIN_N-1:0] method_q, dual_q, pol_q, pending;

   gpio_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_i),
      .q     (lvl_s)
   );

   gpio_event_detect #(.W(PIN_N)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl_s),
      .method (method_q),
      .dual   (dual_q),
      .pol    (pol_q),
      .evt    (evt)
   );

   gpio_regs #(.PIN_N(PIN_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .we       (bus_we),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .lvl      (lvl_s),
      .evt      (evt),
      .dir_q    (dir_q),
      .out_q    (out_q),
      .en_q     (en_q),
      .mask_q   (mask_q),
      .raw_q    (raw_q),
      .method_q (method_q),
      .dual_q   (dual_q),
      .pol_q    (pol_q),
      .pending  (pending)
   );

   assign pin_oe_o  = dir_q;
   assign pin_out_o = out_q;
   assign irq_o     = |pending;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
   parameter int unsigned PIN_N  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [PIN_N-1:0]  pin_oe_o,
   input logic [PIN_N-1:0]  pin_out_o,
   input logic              irq_o,
   input logic [PIN_N-1:0]  raw_q,
   input logic [PIN_N-1:0]  en_q,
   input logic [PIN_N-1:0]  mask_q
);
   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(8'h10);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(8'h14);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(8'h08);
   localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(8'h30);

   // R3
   out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_SET) |=>
         ((pin_out_o & $past(bus_wdata[PIN_N-1:0])) == $past(bus_wdata[PIN_N-1:0])));

   // R3
   out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_CLR) |=> ((pin_out_o & $past(bus_wdata[PIN_N-1:0])) == '0));

   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(pin_out_o));

   // R2
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == A_DIR) |=> $stable(pin_oe_o));

   // R9
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_ACK) |=> ((raw_q & $past(bus_wdata[PIN_N-1:0])) == '0));

   // R8
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((raw_q & ~$past(raw_q)) & ~$past(en_q)) == '0));

   // R10
   full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == {PIN_N{1'b1}}) |-> !irq_o);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.PIN_N(PIN_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .pin_oe_o  (pin_oe_o),
   .pin_out_o (pin_out_o),
   .irq_o     (irq_o),
   .raw_q     (raw_q),
   .en_q      (en_q),
   .mask_q    (mask_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
   localparam logic [7:0] A_LVL = 8'h04, A_DIR = 8'h08, A_SET = 8'h10, A_CLR = 8'h14;
   localparam logic [7:0] A_EN = 8'h20, A_RAW = 8'h24, A_PEND = 8'h28, A_MASK = 8'h2C;
   localparam logic [7:0] A_ACK = 8'h30, A_METH = 8'h34, A_DUAL = 8'h38, A_POL = 8'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_i = '0;
   logic [31:0] pin_oe_o, pin_out_o;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   gpio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
      .pin_oe_o(pin_oe_o), .pin_out_o(pin_out_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tidy();
      wr(A_EN, '0); wr(A_METH, '0); wr(A_DUAL, '0); wr(A_POL, '0); wr(A_MASK, '0);
      @(negedge clk); pin_i = '0;
      step(4);
      wr(A_ACK, '1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 64; a += 4) begin
         rd(8'(a), v);
         chk($sformatf("R1 reg %02h after reset", a), v, '0);
      end
      chk("R1 pin_oe_o", pin_oe_o, '0);
      chk("R1 pin_out_o", pin_out_o, '0);
      chk("R1 irq_o", {31'b0, irq_o}, '0);
   endtask

   task automatic t_dir();
      logic [31:0] v;
      wr(A_DIR, 32'h0000_F0F0);
      chk("R2 pin_oe_o", pin_oe_o, 32'h0000_F0F0);
      rd(A_DIR, v);
      chk("R2 readback", v, 32'h0000_F0F0);
   endtask

   task automatic t_outputs();
      logic [31:0] v;
      wr(A_SET, 32'h0000_000F);
      wr(A_SET, 32'h8000_0030);
      chk("R3 set accumulates", pin_out_o, 32'h8000_003F);
      wr(A_CLR, 32'h0000_0005);
      chk("R3 clear marked", pin_out_o, 32'h8000_003A);
      rd(A_SET, v);
      chk("R3 set offset readback", v, 32'h8000_003A);
      rd(A_CLR, v);
      chk("R3 clear offset readback", v, 32'h8000_003A);
   endtask

   task automatic t_sync();
      logic [31:0] v;
      @(negedge clk); pin_i = 32'hA5A5_0001;
      step(1); rd(A_LVL, v);
      chk("R4 one edge not yet visible", v, '0);
      step(1); rd(A_LVL, v);
      chk("R4 visible after two edges", v, 32'hA5A5_0001);
      tidy();
   endtask

   task automatic t_single_edge();
      logic [31:0] v;
      // pin0 rising (pol 0), pin1 falling (pol 1)
      wr(A_POL, 32'h2); wr(A_EN, 32'h3);
      @(negedge clk); pin_i = 32'h3;
      step(2); rd(A_RAW, v);
      chk("R5 not before third edge", v, '0);
      step(1); rd(A_RAW, v);
      chk("R5 rising latched, falling pin quiet", v, 32'h1);
      chk("R10 irq_o on rising", {31'b0, irq_o}, 32'h1);
      wr(A_ACK, 32'h1);
      @(negedge clk); pin_i = '0;
      step(3); rd(A_RAW, v);
      chk("R5 falling latched, rising pin quiet", v, 32'h2);
      tidy();
   endtask

   task automatic t_both();
      logic [31:0] v;
      wr(A_DUAL, 32'h4); wr(A_POL, 32'h4); wr(A_EN, 32'h4);
      @(negedge clk); pin_i = 32'h4;
      step(3); rd(A_RAW, v);
      chk("R6 rise with polarity 1", v, 32'h4);
      wr(A_ACK, 32'h4);
      @(negedge clk); pin_i = '0;
      step(3); rd(A_RAW, v);
      chk("R6 fall latched", v, 32'h4);
      tidy();
   endtask

   task automatic t_level();
      logic [31:0] v;
      // pin3 active high
      wr(A_METH, 32'h8); wr(A_EN, 32'h8);
      @(negedge clk); pin_i = 32'h8;
      step(3); rd(A_RAW, v);
      chk("R7 high level latched", v, 32'h8);
      wr(A_ACK, 32'h8); rd(A_RAW, v);
      chk("R9 ack wins in its cycle", v, '0);
      step(1); rd(A_RAW, v);
      chk("R7 re-sets while level active", v, 32'h8);
      @(negedge clk); pin_i = '0;
      step(3); wr(A_ACK, 32'h8); step(2); rd(A_RAW, v);
      chk("R7 stays clear once inactive", v, '0);
      tidy();
      // pin4 active low, pin held low
      wr(A_METH, 32'h10); wr(A_POL, 32'h10); wr(A_EN, 32'h10);
      step(1); rd(A_RAW, v);
      chk("R7 low level latched", v, 32'h10);
      tidy();
   endtask

   task automatic t_enable();
      logic [31:0] v;
      wr(A_EN, 32'h40);
      @(negedge clk); pin_i = 32'h20;
      step(4); rd(A_RAW, v);
      chk("R8 disabled pin ignored", v, '0);
      chk("R8 irq_o stays low", {31'b0, irq_o}, '0);
      tidy();
   endtask

   task automatic t_mask_ack();
      logic [31:0] v;
      wr(A_MASK, 32'h40); wr(A_EN, 32'h1C0);
      @(negedge clk); pin_i = 32'h1C0;
      step(3); rd(A_RAW, v);
      chk("R10 raw independent of mask", v, 32'h1C0);
      rd(A_PEND, v);
      chk("R10 masked status", v, 32'h180);
      wr(A_ACK, 32'h180); rd(A_RAW, v);
      chk("R9 only marked bits cleared", v, 32'h40);
      chk("R10 irq_o low when all masked", {31'b0, irq_o}, '0);
      wr(A_MASK, '0); rd(A_PEND, v);
      chk("R10 unmask shows pending", v, 32'h40);
      chk("R10 irq_o after unmask", {31'b0, irq_o}, 32'h1);
      tidy();
   endtask

   initial begin
      step(3);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_dir();
      t_outputs();
      t_sync();
      t_single_edge();
      t_both();
      t_level();
      t_enable();
      t_mask_ack();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule